// File: doc/BRIEF.md
# Accumulator Sequencer with Interrupt Entry

This block is the control path of a small accumulator machine. It keeps a program counter, a memory address register, a memory buffer, the current opcode, an accumulator, a stack pointer and a three-bit condition register. It walks each instruction through fetch, an optional operand-word fetch, execute and, when requested, an interrupt entry. All of its traffic goes through one synchronous memory port. Read data arrives on the clock after the read strobe.

The instruction set holds load, add and store (each with a direct address), a no-operation, return-from-interrupt and halt. Any memory instruction can carry its address either in its own low bits or in a following word. In the second case it occupies two words. The `BYTE_ADDR` parameter picks how the program counter and stack pointer move: by one per word, or by the word's byte count. The block responds to an interrupt request only at an instruction boundary. On entry it pushes the address of the next instruction onto a downward-growing stack, then jumps to a fixed service address and masks further requests until the return instruction.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is high, both memory strobes, `halted` and `flags` are low. In the cycle after reset falls, a read strobe appears at address `RESET_PC`.
- R2: Each word fetch runs in this order: the program counter is copied to the address register, a read strobe is driven for one cycle, the returned word is captured on the following clock, and then the program counter advances. A read strobe and a write strobe are never high together.
- R3: The program counter advances by 1 for each fetched word when `BYTE_ADDR`=0 and by `DATA_W/8` when `BYTE_ADDR`=1. A two-word instruction at address a is followed by the next fetch at a+2 (word mode) or a+8 (byte mode, 32-bit data).
- R4: Encoding: the opcode is in bits [31:28], with 0 = no-op, 1 = load, 2 = add, 3 = store, 14 = return, 15 = halt. For codes 1 to 3, bit 27 set means the operand address is the next word, which is fetched at the advanced PC. Bit 27 clear means the address is bits [ADDR_W-1:0].
- R5: Load sets AC to M[addr]. Add sets AC to AC + M[addr], modulo 2^DATA_W.
- R6: Only add updates `flags`, with bit 0 = carry out, bit 1 = result zero and bit 2 = signed overflow.
- R7: Store writes AC to its operand address with a single write strobe.
- R8: A request raised while an instruction is in progress, including during its operand-word fetch, is taken only after that instruction has finished, including its memory write.
- R9: Interrupt entry decrements SP by one step, writes the address of the next instruction to the new SP, and then fetches from `ISR_ADDR`.
- R10: From entry until a return executes, further requests are ignored. A request held high through the service routine causes only one push.
- R11: Return reads the word at SP, increments SP by one step, and resumes fetching at that word's value.
- R12: After halt, `halted` stays high and no strobe is driven until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level interrupt request |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High once a halt has executed |
| flags | output | 3 | {overflow, zero, carry} from the last add |

## Verification
The case that matters most is an interrupt request that arrives while a two-word store is still fetching its operand word. At that point a request and an unfinished instruction overlap. The bench raises the request on the cycle the operand word is read and keeps it high through the service routine. It then checks three things: the store's write lands before the stack push, the pushed address is the word after the two-word store, and only one push occurs. Both addressing modes run the same program, and the read and write address sequences are compared against lists scaled by the mode's step.

// File: rtl/accseq_pkg.sv
package accseq_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_ADD   = 4'h2,
        OP_STORE = 4'h3,
        OP_RETI  = 4'hE,
        OP_HALT  = 4'hF
    } op_e;

    typedef enum logic [3:0] {
        S_FA, S_FR, S_FM, S_FI,
        S_OA, S_OR, S_OM, S_OI,
        S_EX, S_DR, S_DM, S_DW,
        S_SW, S_IP, S_IW, S_HALT
    } state_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
    } flags_t;

    function automatic logic is_mem_op(op_e op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);
    endfunction

endpackage

// File: rtl/accseq_step.sv
module accseq_step #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter bit BYTE_ADDR = 1'b0,
    parameter bit DOWN      = 1'b0
) (
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] result
);
    localparam int STEP = BYTE_ADDR ? DATA_W / 8 : 1;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    generate
        if (DOWN) begin : g_down
            assign result = base - STEP_V;
        end else begin : g_up
            assign result = base + STEP_V;
        end
    endgenerate
endmodule

// File: rtl/accseq_add.sv
module accseq_add
    import accseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output flags_t            fl
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide     = {1'b0, a} + {1'b0, b};
        sum      = wide[DATA_W-1:0];
        fl.carry = wide[DATA_W];
        fl.zero  = (wide[DATA_W-1:0] == '0);
        fl.ovf   = (a[DATA_W-1] == b[DATA_W-1]) && (wide[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import accseq_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 16,
    parameter bit                BYTE_ADDR = 1'b0,
    parameter logic [ADDR_W-1:0] RESET_PC  = '0,
    parameter logic [ADDR_W-1:0] ISR_ADDR  = ADDR_W'(64),
    parameter logic [ADDR_W-1:0] SP_INIT   = ADDR_W'(256)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted,
    output logic [2:0]        flags
);
    localparam int STEP = BYTE_ADDR ? DATA_W / 8 : 1;
    localparam int PAD  = DATA_W - ADDR_W;

    state_e            state;
    op_e               ir_op;
    logic [ADDR_W-1:0] pc, mar, sp, opaddr;
    logic [DATA_W-1:0] mbr, ac;
    flags_t            st;
    logic              ie;

    logic [ADDR_W-1:0] pc_next, sp_up, sp_dn;
    logic [DATA_W-1:0] add_sum;
    flags_t            add_fl;
    op_e               fetched_op;
    state_e            boundary;

    accseq_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_ADDR(BYTE_ADDR), .DOWN(1'b0))
        u_pc_inc (.base(pc), .result(pc_next));
    accseq_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_ADDR(BYTE_ADDR), .DOWN(1'b0))
        u_sp_inc (.base(sp), .result(sp_up));
    accseq_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_ADDR(BYTE_ADDR), .DOWN(1'b1))
        u_sp_dec (.base(sp), .result(sp_dn));
    accseq_add #(.DATA_W(DATA_W))
        u_alu (.a(ac), .b(mbr), .sum(add_sum), .fl(add_fl));

    assign fetched_op = op_e'(mbr[DATA_W-1 -: OP_W]);
    assign boundary   = (irq && ie) ? S_IP : S_FA;

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_rd    = (state == S_FR) || (state == S_OR) || (state == S_DR);
    assign mem_wr    = (state == S_SW) || (state == S_IW);
    assign halted    = (state == S_HALT);
    assign flags     = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_FA;
            ir_op  <= OP_NOP;
            pc     <= RESET_PC;
            mar    <= '0;
            sp     <= SP_INIT;
            opaddr <= '0;
            mbr    <= '0;
            ac     <= '0;
            st     <= '0;
            ie     <= 1'b1;
        end else begin
            unique case (state)
                S_FA: begin mar <= pc; state <= S_FR; end
                S_FR: state <= S_FM;
                S_FM: begin mbr <= mem_rdata; state <= S_FI; end
                S_FI: begin
                    ir_op <= fetched_op;
                    pc    <= pc_next;
                    if (is_mem_op(fetched_op) && mbr[DATA_W-OP_W-1]) begin
                        state <= S_OA;
                    end else begin
                        opaddr <= mbr[ADDR_W-1:0];
                        state  <= S_EX;
                    end
                end
                S_OA: begin mar <= pc; state <= S_OR; end
                S_OR: state <= S_OM;
                S_OM: begin mbr <= mem_rdata; state <= S_OI; end
                S_OI: begin
                    opaddr <= mbr[ADDR_W-1:0];
                    pc     <= pc_next;
                    state  <= S_EX;
                end
                S_EX: begin
                    case (ir_op)
                        OP_LOAD, OP_ADD: begin mar <= opaddr; state <= S_DR; end
                        OP_STORE:        begin mar <= opaddr; mbr <= ac; state <= S_SW; end
                        OP_RETI:         begin mar <= sp; state <= S_DR; end
                        OP_HALT:         state <= S_HALT;
                        default:         state <= boundary;
                    endcase
                end
                S_DR: state <= S_DM;
                S_DM: begin mbr <= mem_rdata; state <= S_DW; end
                S_DW: begin
                    case (ir_op)
                        OP_LOAD: ac <= mbr;
                        OP_ADD:  begin ac <= add_sum; st <= add_fl; end
                        OP_RETI: begin pc <= mbr[ADDR_W-1:0]; sp <= sp_up; ie <= 1'b1; end
                        default: ;
                    endcase
                    state <= boundary;
                end
                S_SW: state <= boundary;
                S_IP: begin
                    sp    <= sp_dn;
                    mar   <= sp_dn;
                    mbr   <= {{PAD{1'b0}}, pc};
                    ie    <= 1'b0;
                    state <= S_IW;
                end
                S_IW: begin pc <= ISR_ADDR; state <= S_FA; end
                S_HALT: state <= S_HALT;
                default: state <= S_FA;
            endcase
        end
    end

    // R2: the two strobes are exclusive
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R12: halt is sticky and silent
    a_r12_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    a_r12_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    // R9: push writes the return PC at the decremented SP
    a_r9_push_data: assert property (@(posedge clk) disable iff (rst)
        (state == S_IW) |-> (mem_wdata == {{PAD{1'b0}}, pc}) && (mem_addr == sp));
    a_r9_sp_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_IP) |=> (sp == $past(sp) - ADDR_W'(STEP)));

    // R10: entry masks further requests
    a_r10_masked: assert property (@(posedge clk) disable iff (rst)
        (state == S_IW) |-> !ie);

    // R3: each word fetch advances PC by one step
    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_FI) |=> (pc == $past(pc) + ADDR_W'(STEP)));
endmodule

// File: tb/acc_seq_core_tb.sv
module acc_seq_core_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] w(logic [3:0] op, logic lng, logic [15:0] a);
        return {op, lng, 11'b0, a};
    endfunction

    for (genvar m = 0; m < 2; m++) begin : g_mode
        localparam bit BA   = (m == 1);
        localparam int STEP = BA ? 4 : 1;

        logic        rst = 1'b1;
        logic        irq = 1'b0;
        logic        mem_rd, mem_wr, halted;
        logic [15:0] mem_addr;
        logic [31:0] mem_wdata;
        logic [31:0] mem_rdata = '0;
        logic [2:0]  flags;
        logic [31:0] mem [0:511];
        bit          done = 1'b0;
        bit          logging = 1'b0;
        int          nr, nw;
        logic [15:0] rlog [0:63];
        logic [15:0] wlog_a [0:15];
        logic [31:0] wlog_d [0:15];

        acc_seq_core #(
            .BYTE_ADDR(BA),
            .RESET_PC(16'(100 * STEP)),
            .ISR_ADDR(16'(150 * STEP)),
            .SP_INIT(16'(300 * STEP))
        ) u_dut (
            .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
            .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
            .mem_wr(mem_wr), .halted(halted), .flags(flags)
        );

        function automatic logic [15:0] A(int x);
            return 16'(x * STEP);
        endfunction

        function automatic int idx(logic [15:0] a);
            return (int'(a) / STEP) % 512;
        endfunction

        always @(posedge clk) begin
            if (mem_rd) mem_rdata <= mem[idx(mem_addr)];
            if (mem_wr) mem[idx(mem_addr)] <= mem_wdata;
            if (logging && !rst) begin
                if (mem_rd && nr < 64) begin rlog[nr] = mem_addr; nr++; end
                if (mem_wr && nw < 16) begin wlog_a[nw] = mem_addr; wlog_d[nw] = mem_wdata; nw++; end
            end
        end

        task automatic load_prog();
            for (int i = 0; i < 512; i++) mem[i] = 32'hDEAD_BEEF;
            mem[100] = w(4'h1, 1'b1, 16'h0);     // R4 two-word load
            mem[101] = {16'h0, A(200)};
            mem[102] = w(4'h2, 1'b0, A(201));
            mem[103] = w(4'h2, 1'b0, A(202));
            mem[104] = w(4'h3, 1'b1, 16'h0);     // two-word store
            mem[105] = {16'h0, A(210)};
            mem[106] = w(4'h1, 1'b0, A(203));
            mem[107] = w(4'h2, 1'b0, A(204));
            mem[108] = w(4'h3, 1'b0, A(211));
            mem[109] = w(4'hF, 1'b0, 16'h0);
            mem[150] = w(4'h3, 1'b0, A(212));
            mem[151] = w(4'hE, 1'b0, 16'h0);
            mem[200] = 32'd5;
            mem[201] = 32'd7;
            mem[202] = 32'hFFFF_FFF4;
            mem[203] = 32'h7FFF_FFFF;
            mem[204] = 32'd1;
        endtask

        task automatic run(bit with_irq);
            int er [0:31];
            int ne;
            int ew_a [0:3];
            logic [31:0] ew_d [0:3];
            int nwe;
            load_prog();
            rst = 1'b1; irq = 1'b0; logging = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk("R1 rd in reset", {31'b0, mem_rd}, 32'd0);
            chk("R1 wr in reset", {31'b0, mem_wr}, 32'd0);
            chk("R1 halted in reset", {31'b0, halted}, 32'd0);
            chk("R1 flags in reset", {29'b0, flags}, 32'd0);
            nr = 0; nw = 0; logging = 1'b1;
            rst = 1'b0;
            @(posedge clk); @(negedge clk);
            chk("R1 first fetch strobe", {31'b0, mem_rd}, 32'd1);
            chk("R1 first fetch addr", {16'b0, mem_addr}, {16'b0, A(100)});
            while (!(mem_rd && mem_addr == A(103))) @(negedge clk);
            chk("R6 flags after 5+7", {29'b0, flags}, 32'd0);
            chk("R5 fetch 103 two cycles apart", 32'(nr), 32'd5);
            while (!(mem_rd && mem_addr == A(104))) @(negedge clk);
            chk("R6 flags after 12-12 (carry,zero)", {29'b0, flags}, 32'b011);
            if (with_irq) begin
                while (!(mem_rd && mem_addr == A(105))) @(negedge clk);
                irq = 1'b1;
                while (!(mem_wr && mem_addr == A(299))) @(negedge clk);
                chk("R9 pushed return addr", mem_wdata, {16'b0, A(106)});
                chk("R8 store finished before push", 32'(nw), 32'd1);
                while (!(mem_rd && mem_addr == A(106))) @(negedge clk);
                irq = 1'b0;
            end
            while (!halted) @(negedge clk);
            ne = 0;
            foreach (er[k]) er[k] = 0;
            er[ne++] = 100; er[ne++] = 101; er[ne++] = 200;
            er[ne++] = 102; er[ne++] = 201; er[ne++] = 103; er[ne++] = 202;
            er[ne++] = 104; er[ne++] = 105;
            if (with_irq) begin er[ne++] = 150; er[ne++] = 151; er[ne++] = 299; end
            er[ne++] = 106; er[ne++] = 203; er[ne++] = 107; er[ne++] = 204;
            er[ne++] = 108; er[ne++] = 109;
            chk("R2 read count", 32'(nr), 32'(ne));
            for (int k = 0; k < ne && k < nr; k++)
                chk(with_irq ? "R3 R4 R11 read order" : "R3 R4 read order",
                    {16'b0, rlog[k]}, {16'b0, A(er[k])});
            nwe = 0;
            ew_a[nwe] = 210; ew_d[nwe] = 32'd0; nwe++;
            if (with_irq) begin
                ew_a[nwe] = 299; ew_d[nwe] = {16'b0, A(106)}; nwe++;
                ew_a[nwe] = 212; ew_d[nwe] = 32'd0; nwe++;
            end
            ew_a[nwe] = 211; ew_d[nwe] = 32'h8000_0000; nwe++;
            chk("R10 write count (one push)", 32'(nw), 32'(nwe));
            for (int k = 0; k < nwe && k < nw; k++) begin
                chk("R7 R9 write addr", {16'b0, wlog_a[k]}, {16'b0, A(ew_a[k])});
                chk("R5 R7 write data", wlog_d[k], ew_d[k]);
            end
            chk("R6 final flags (overflow)", {29'b0, flags}, 32'b100);
            begin
                int seen = 0;
                for (int c = 0; c < 20; c++) begin
                    @(negedge clk);
                    if (mem_rd || mem_wr || !halted) seen++;
                end
                chk("R12 quiet and halted", 32'(seen), 32'd0);
            end
            logging = 1'b0;
        endtask

        initial begin
            run(1'b0);
            run(1'b1);
            done = 1'b1;
        end
    end

    initial begin
        wait (g_mode[0].done && g_mode[1].done);
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R12 actual=running expected=halted");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule